// File: doc/BRIEF.md
# Packed Q15 Complex Multiplier

This block multiplies two complex numbers held in 32-bit words and returns their product in the same packed form. It is meant to sit inside a fixed-point FFT butterfly or a complex filter. Each word carries a signed 16-bit real part in bits 15:0 and a signed 16-bit imaginary part in bits 31:16. The unit forms all four partial products at full 32-bit precision. It can double each product to align Q15 operands, and it combines the products into a real and an imaginary sum. It can add a half-LSB rounding term, clamps each sum to the signed 32-bit range and returns the upper halfword of each clamped sum.

A caller streams operand pairs through a valid/ready handshake. The pipeline has three register stages and accepts one operation per cycle while the consumer keeps up. When the consumer stalls, every stage holds together. A sticky flag records that at least one result part was clamped. A dedicated input clears it.

Top module: `cplx_q15_mul`

## Requirements
- R1: Operands and result use the same packing: the real part is in bits 15:0 and the imaginary part is in bits 31:16. Both parts are two's-complement signed.
- R2: Real = a.re*b.re − a.im*b.im and imag = a.re*b.im + a.im*b.re. Each product is a full 32-bit signed product, and the sums are formed without loss before any clamping.
- R3: When `shiftOne` is 1, every product is doubled (shifted left by one) before summation. When it is 0, the products are used unshifted.
- R4: When `roundOn` is 1, 0x8000 is added to each sum before clamping. When it is 0, no rounding term is added and the result is a plain truncation to the high halfword.
- R5: Each rounded sum is clamped to [−2^31, 2^31−1], and bits 31:16 of the clamped value form the output part. For example, both operands at 0x80008000 with doubling and rounding give 0x7FFF0000.
- R6: `satSticky` goes to 1 after the edge that loads the output stage with a result in which either part was clamped. It stays at 1 until a cycle with `satClr` high, and a new clamp in that same cycle keeps it at 1. A result with no clamp leaves the flag unchanged.
- R7: An operation accepted at a rising edge (`inValid` and `inReady` both high) shows up on `outData` with `outValid` high after the second rising edge that follows, provided `outReady` stays high.
- R8: `inReady` is high whenever the output stage is empty or `outReady` is high. Back-to-back operations are accepted at one per cycle, and results come out in issue order.
- R9: While `outValid` is high and `outReady` is low, `outData` and `outValid` hold, `inReady` stays low once all three stages are full, and no operation is lost or reordered.
- R10: After reset, `outValid` and `satSticky` are 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair is valid |
| inReady | output | 1 | Unit accepts an operand pair this cycle |
| opA | input | 32 | First packed complex operand |
| opB | input | 32 | Second packed complex operand |
| shiftOne | input | 1 | Double each product (Q15 alignment) |
| roundOn | input | 1 | Add the half-LSB rounding term |
| outValid | output | 1 | Result is valid |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | 32 | Packed complex result |
| satClr | input | 1 | Clear the sticky clamp flag |
| satSticky | output | 1 | Sticky flag: some result part was clamped |

## Verification
A control or data register that is stuck or mis-stepped shows at the ports within the three-cycle latency. It appears as a missing or duplicated valid, or as a result paired with the wrong operands in a backpressured stream. A stall that does not freeze all stages shows as a changed `outData` in the first held cycle. An error in sum width or in the clamp point shows only for operands near full scale, so the near-full-scale corners are driven explicitly. A rounding error shows only when the low halfword of a sum sits at the carry boundary, so that boundary is driven on both signs. A flag that sets on the wrong stage, or that does not persist, differs from the expected value one edge after the clamped result lands.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // Strobes the pipeline control hands to the datapath.
  typedef struct packed {
    logic adv;     // every stage advances this cycle
    logic fillS2;  // stage 2 holds a live operation
  } cmulStb_t;

  // Product slot indices inside the datapath.
  localparam int unsigned IdxRR = 0;  // a.re * b.re
  localparam int unsigned IdxII = 1;  // a.im * b.im
  localparam int unsigned IdxRI = 2;  // a.re * b.im
  localparam int unsigned IdxIR = 3;  // a.im * b.re
  localparam int unsigned NumProd = 4;

endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
  import cmul_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output cmulStb_t stb
);

  logic v1Q, v2Q, v3Q;
  logic advance;

  // All stages move together. The last stage frees up when it is empty or drained.
  assign advance = !v3Q || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
      v3Q <= 1'b0;
    end else if (advance) begin
      v1Q <= inValid;
      v2Q <= v1Q;
      v3Q <= v2Q;
    end
  end

  assign inReady    = advance;
  assign outValid   = v3Q;
  assign stb.adv    = advance;
  assign stb.fillS2 = v2Q;

  // R8: an accepted operation occupies stage 1 on the next cycle
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> v1Q);

  // R10: reset empties the output stage
  assert_reset_R10: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

// File: rtl/cmul_dpath.sv
module cmul_dpath
  import cmul_pkg::*;
#(
  parameter int unsigned PartW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmulStb_t           stb,
  input  logic [2*PartW-1:0] opA,
  input  logic [2*PartW-1:0] opB,
  input  logic               shiftOne,
  input  logic               roundOn,
  input  logic               satClr,
  output logic [2*PartW-1:0] resData,
  output logic               satSticky
);

  localparam int unsigned ProdW = 2 * PartW;       // full product width
  localparam int unsigned ShW   = ProdW + 1;       // product after optional doubling
  localparam int unsigned SumW  = ProdW + 3;       // lossless sum width
  localparam int unsigned HiW   = SumW - ProdW + 1; // bits that must agree when in range
  localparam logic [PartW-1:0] PartMax = {1'b0, {(PartW-1){1'b1}}};
  localparam logic [PartW-1:0] PartMin = {1'b1, {(PartW-1){1'b0}}};

  // ---------------- stage 1: multiply ----------------
  logic signed [PartW-1:0] facA [NumProd];
  logic signed [PartW-1:0] facB [NumProd];
  logic signed [ProdW-1:0] prodQ [NumProd];
  logic shiftQ, roundS1Q;

  always_comb begin
    facA[IdxRR] = opA[PartW-1:0];       facB[IdxRR] = opB[PartW-1:0];
    facA[IdxII] = opA[2*PartW-1:PartW]; facB[IdxII] = opB[2*PartW-1:PartW];
    facA[IdxRI] = opA[PartW-1:0];       facB[IdxRI] = opB[2*PartW-1:PartW];
    facA[IdxIR] = opA[2*PartW-1:PartW]; facB[IdxIR] = opB[PartW-1:0];
  end

  always_ff @(posedge clk) begin
    if (stb.adv) begin
      for (int i = 0; i < NumProd; i++) begin
        prodQ[i] <= ProdW'(facA[i]) * ProdW'(facB[i]);
      end
      shiftQ   <= shiftOne;
      roundS1Q <= roundOn;
    end
  end

  // ---------------- stage 2: align and sum ----------------
  logic signed [ShW-1:0]  shProd [NumProd];
  logic signed [SumW-1:0] sumQ [2];
  logic roundS2Q;

  for (genvar g = 0; g < NumProd; g++) begin : gAlign
    assign shProd[g] = shiftQ ? {prodQ[g], 1'b0} : {prodQ[g][ProdW-1], prodQ[g]};
  end

  always_ff @(posedge clk) begin
    if (stb.adv) begin
      sumQ[0]  <= SumW'(shProd[IdxRR]) - SumW'(shProd[IdxII]);
      sumQ[1]  <= SumW'(shProd[IdxRI]) + SumW'(shProd[IdxIR]);
      roundS2Q <= roundS1Q;
    end
  end

  // ---------------- stage 3: round, clamp, take high half ----------------
  logic [SumW-1:0]  rndConst;
  logic [SumW-1:0]  rndSum [2];
  logic [PartW-1:0] partNext [2];
  logic [1:0]       clip;
  logic             unusedLowBits;

  assign rndConst = {{(SumW-PartW){1'b0}}, roundS2Q, {(PartW-1){1'b0}}};

  for (genvar g = 0; g < 2; g++) begin : gLane
    logic [HiW-1:0] hiBits;
    assign rndSum[g] = sumQ[g] + rndConst;
    assign hiBits    = rndSum[g][SumW-1:ProdW-1];
    assign clip[g]   = !((&hiBits) || !(|hiBits));
    assign partNext[g] = clip[g] ? (rndSum[g][SumW-1] ? PartMin : PartMax)
                                 : rndSum[g][ProdW-1:PartW];
  end

  assign unusedLowBits = ^{rndSum[0][PartW-1:0], rndSum[1][PartW-1:0]};

  logic [2*PartW-1:0] resQ;
  logic satQ;

  always_ff @(posedge clk) begin
    if (stb.adv) begin
      resQ <= {partNext[1], partNext[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      satQ <= 1'b0;
    end else if (stb.adv && stb.fillS2 && (|clip)) begin
      satQ <= 1'b1;
    end else if (satClr) begin
      satQ <= 1'b0;
    end
  end

  assign resData   = resQ;
  assign satSticky = satQ;

  // R6: the sticky flag only drops after a clear request
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(satQ) |-> $past(satClr));

  // R5: a clamped real part lands on a full-scale code
  assert_clip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.adv && stb.fillS2 && clip[0]) |=>
      (resQ[PartW-1:0] == PartMax || resQ[PartW-1:0] == PartMin));

endmodule

// File: rtl/cplx_q15_mul.sv
module cplx_q15_mul
  import cmul_pkg::*;
#(
  parameter int unsigned PartW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [2*PartW-1:0] opA,
  input  logic [2*PartW-1:0] opB,
  input  logic               shiftOne,
  input  logic               roundOn,
  output logic               outValid,
  input  logic               outReady,
  output logic [2*PartW-1:0] outData,
  input  logic               satClr,
  output logic               satSticky
);

  cmulStb_t stb;

  cmul_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  cmul_dpath #(.PartW(PartW)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .opA       (opA),
    .opB       (opB),
    .shiftOne  (shiftOne),
    .roundOn   (roundOn),
    .satClr    (satClr),
    .resData   (outData),
    .satSticky (satSticky)
  );

  // R9: a stalled result holds its value and validity
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

// File: tb/test_cplx_q15_mul.sv
`timescale 1ns/1ps
module test_cplx_q15_mul;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [31:0] opA = '0, opB = '0;
  logic shiftOne = 1'b0, roundOn = 1'b0;
  logic outValid, outReady = 1'b1;
  logic [31:0] outData;
  logic satClr = 1'b0, satSticky;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cplx_q15_mul i_cplx_q15_mul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .shiftOne(shiftOne), .roundOn(roundOn),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .satClr(satClr), .satSticky(satSticky)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference arithmetic straight from the requirements, in 64-bit integers.
  function automatic logic [15:0] refPart(input longint s, input logic rd);
    longint v = s + (rd ? 64'sd32768 : 64'sd0);
    if (v > 64'sd2147483647) v = 64'sd2147483647;
    if (v < -64'sd2147483648) v = -64'sd2147483648;
    return v[31:16];
  endfunction

  function automatic logic [31:0] refMul(input logic [31:0] a, input logic [31:0] b,
                                         input logic sh, input logic rd);
    longint ar = longint'($signed(a[15:0]));
    longint ai = longint'($signed(a[31:16]));
    longint br = longint'($signed(b[15:0]));
    longint bi = longint'($signed(b[31:16]));
    longint k = sh ? 2 : 1;
    longint re = k * ar * br - k * ai * bi;
    longint im = k * ar * bi + k * ai * br;
    return {refPart(im, rd), refPart(re, rd)};
  endfunction

  // Issue one operation with outReady high and return the result after the latency.
  task automatic runOne(input logic [31:0] a, input logic [31:0] b, input logic sh,
                        input logic rd, output logic [31:0] res);
    @(negedge clk);
    outReady = 1'b1;
    opA = a; opB = b; shiftOne = sh; roundOn = rd; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    res = outData;
  endtask

  task automatic tReset();
    chk("R10 outValid after reset", {31'd0, outValid}, 32'd0);
    chk("R10 satSticky after reset", {31'd0, satSticky}, 32'd0);
    chk("R10 inReady after reset", {31'd0, inReady}, 32'd1);
  endtask

  task automatic tLatency();
    int seen [3];
    @(negedge clk);
    opA = 32'h0000_4000; opB = 32'h0000_4000; shiftOne = 1; roundOn = 1; inValid = 1;
    @(posedge clk);
    for (int e = 0; e < 3; e++) begin
      @(negedge clk);
      inValid = 1'b0;
      seen[e] = outValid;
      if (e < 2) @(posedge clk);
    end
    // Sampled after the acceptance edge, then after 1 and 2 further edges.
    chk("R7 no result after first edge", 32'(seen[0]), 32'd0);
    chk("R7 no result after second edge", 32'(seen[1]), 32'd0);
    chk("R7 result after third edge", 32'(seen[2]), 32'd1);
    chk("R7 value", outData, 32'h0000_2000);
    @(posedge clk);
  endtask

  task automatic tBasic();
    logic [31:0] r;
    runOne(32'h0000_4000, 32'h2000_4000, 1'b1, 1'b1, r);
    chk("R1 R2 half times (half + quarter j)", r, 32'h1000_2000);
    runOne(32'h4000_0000, 32'h4000_0000, 1'b1, 1'b1, r);   // j*0.5 squared = -0.25
    chk("R2 imag times imag", r, 32'h0000_E000);
    runOne(32'h1234_F00D, 32'hC0DE_0777, 1'b1, 1'b1, r);
    chk("R2 mixed signs", r, refMul(32'h1234_F00D, 32'hC0DE_0777, 1'b1, 1'b1));
    runOne(32'h7FFF_8001, 32'h8001_7FFF, 1'b1, 1'b0, r);
    chk("R2 near full scale", r, refMul(32'h7FFF_8001, 32'h8001_7FFF, 1'b1, 1'b0));
  endtask

  task automatic tShift();
    logic [31:0] r;
    runOne(32'h0000_4000, 32'h2000_4000, 1'b0, 1'b0, r);
    chk("R3 no doubling", r, 32'h0800_1000);
    runOne(32'h0000_4000, 32'h2000_4000, 1'b1, 1'b0, r);
    chk("R3 doubling", r, 32'h1000_2000);
  endtask

  task automatic tRound();
    logic [31:0] r;
    // re = 0x0100*0x0080 = 0x8000; im = -0x8000
    runOne(32'h0000_0100, 32'hFF80_0080, 1'b0, 1'b1, r);
    chk("R4 rounding on at carry boundary", r, 32'h0000_0001);
    runOne(32'h0000_0100, 32'hFF80_0080, 1'b0, 1'b0, r);
    chk("R4 rounding off truncates", r, 32'hFFFF_0000);
  endtask

  task automatic tSat();
    logic [31:0] r;
    @(negedge clk); satClr = 1'b1;
    @(negedge clk); satClr = 1'b0;
    runOne(32'h0000_4000, 32'h0000_4000, 1'b1, 1'b1, r);
    chk("R6 no clamp leaves flag clear", {31'd0, satSticky}, 32'd0);
    runOne(32'h8000_8000, 32'h8000_8000, 1'b1, 1'b1, r);
    chk("R5 positive clamp corner", r, 32'h7FFF_0000);
    chk("R6 flag set by clamp", {31'd0, satSticky}, 32'd1);
    runOne(32'h0000_4000, 32'h0000_4000, 1'b1, 1'b1, r);
    chk("R6 flag persists", {31'd0, satSticky}, 32'd1);
    runOne(32'h7FFF_8000, 32'h7FFF_7FFF, 1'b1, 1'b1, r);
    chk("R5 negative clamp", r, 32'hFFFF_8000);
    @(negedge clk); satClr = 1'b1;
    @(negedge clk); satClr = 1'b0;
    chk("R6 flag cleared", {31'd0, satSticky}, 32'd0);
  endtask

  task automatic tStall();
    logic [31:0] a [3], expv [3];
    logic [31:0] held;
    int accepted = 0;
    for (int i = 0; i < 3; i++) begin
      a[i] = 32'h0100_0200 * (i + 1);
      expv[i] = refMul(a[i], 32'h3000_5000, 1'b1, 1'b1);
    end
    @(negedge clk);
    outReady = 1'b0; opB = 32'h3000_5000; shiftOne = 1; roundOn = 1;
    for (int c = 0; c < 6; c++) begin
      inValid = (accepted < 3);
      opA = a[accepted < 3 ? accepted : 0];
      #0.5;
      if (inValid && inReady) accepted++;
      @(negedge clk);
    end
    inValid = 1'b0;
    chk("R9 three accepted before full", 32'(accepted), 32'd3);
    chk("R9 inReady low when full", {31'd0, inReady}, 32'd0);
    held = outData;
    for (int c = 0; c < 3; c++) @(negedge clk);
    chk("R9 outValid held", {31'd0, outValid}, 32'd1);
    chk("R9 outData held", outData, held);
    for (int i = 0; i < 3; i++) begin
      outReady = 1'b1;
      #0.5;
      chk("R9 drain order", outData, expv[i]);
      @(negedge clk);
    end
    chk("R9 drained", {31'd0, outValid}, 32'd0);
  endtask

  task automatic tStream();
    localparam int N = 24;
    logic [31:0] a [N], b [N], expv [N];
    int sent = 0, recv = 0, cyc = 0;
    for (int i = 0; i < N; i++) begin
      a[i] = {16'(i * 4099 + 17), 16'(i * 7919 - 300)};
      b[i] = {16'(i * 3001 + 11), 16'(32000 - i * 2711)};
      expv[i] = refMul(a[i], b[i], i[0], i[1]);
    end
    while (recv < N && cyc < 400) begin
      @(negedge clk);
      outReady = (cyc % 5) != 3;
      inValid = (sent < N);
      if (sent < N) begin
        opA = a[sent]; opB = b[sent]; shiftOne = sent[0]; roundOn = sent[1];
      end
      #0.5;
      if (outValid && outReady) begin
        chk("R8 streamed result", outData, expv[recv]);
        recv++;
      end
      if (inValid && inReady) sent++;
      cyc++;
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    chk("R8 all results returned", 32'(recv), 32'(N));
  endtask

  initial begin
    #(5.0 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLatency();
    tBasic();
    tShift();
    tRound();
    tSat();
    tStall();
    tStream();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule